// File: doc/BRIEF.md
# Two-Stage Low-Frequency Tick Counter

This block counts time from a slow clock through two stages. A 15-bit pre-counter advances on every enabled clock cycle. A 32-bit main counter advances on a tick that comes from one of two sources. The first source is a power-of-two division of the clock, taken from the pre-counter's low bits. The second source is a match between the pre-counter and the low bits of an external channel-0 value. Each stage can optionally wrap to zero at an external compare value. With divide-by-32 on a 32768 Hz clock, one main-counter step lasts roughly 977 µs.

Software reaches the block through a simple write port. The register map is: address 0 control, 1 pre-counter, 2 main counter, 3 interrupt enable, 4 lock. Writing the lock register with the unlock key (parameter, default 0x0000C0DE) clears the lock. Writing any other value sets it. A combined readout packs both stages into one 32-bit word. A debug-halt input can freeze counting. The main counter raises a one-cycle overflow pulse each time it wraps.

Top module: `lfc_tick_counter`

## Requirements
- R1: After reset the block is unlocked and stopped, both counters read zero, the overflow pulse is low, and the prescale code is 0.
- R2: The control word at address 0 has these fields: bit 0 run, bit 1 debug-run, bit 2 pre-counter wrap, bit 3 counter wrap, bit 4 match tick mode, bits [11:8] prescale code c. With match mode off, the main counter rises once every 2^c enabled cycles, and the pre-counter rises by one each enabled cycle.
- R3: In match tick mode the main counter increments on the clock edge at which the pre-counter equals `ch0_lo`.
- R4: With pre-counter wrap set, the pre-counter goes to zero on the edge after it equals `ch0_lo`, instead of incrementing.
- R5: With counter wrap set, a tick that finds the main counter equal to `ch1_val` sets it to zero.
- R6: `combined` carries main counter bits [16:0] in bits [31:15] and pre-counter bits [14:0] in bits [14:0].
- R7: While `dbg_halt` is high and debug-run is 0, neither counter changes. With debug-run set, counting continues during halt.
- R8: With run at 0, neither counter changes except by software writes.
- R9: While locked, writes to addresses 0 to 3 are ignored. A lock-register write of the key unlocks the block, and any other value locks it.
- R10: A software write to either counter appears after the next clock edge and takes precedence over that edge's increment.
- R11: `ovf_pulse` is high for the one cycle after the main counter wraps, whether from all-ones or from `ch1_val`. `ovf_irq` equals `ovf_pulse` gated by interrupt-enable bit 0 (address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| dbg_halt | input | 1 | Debug halt indication |
| ch0_lo | input | 15 | Low bits of the channel-0 compare value |
| ch1_val | input | 32 | Channel-1 compare value |
| count | output | 32 | Main counter |
| precount | output | 15 | Pre-counter |
| combined | output | 32 | Packed readout of both stages |
| ovf_pulse | output | 1 | One-cycle main-counter wrap pulse |
| ovf_irq | output | 1 | Enabled overflow interrupt |
| locked | output | 1 | Lock state |

## Verification
Every register write takes effect on the first rising edge after the strobe. The bench drives writes at the falling edge and samples one falling edge later. Counter results are due a known number of edges after the run bit is written, with no counting on the write edge itself, so each expected value is a closed-form count of edges. The wrap pulse is checked in the same cycle that shows the counter at zero, and again one edge later to confirm it has dropped.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_PRE  = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_LOCK = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              match_mode;
    logic              cnt_wrap;
    logic              pre_wrap;
    logic              dbg_run;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/lfc_regs.sv
module lfc_regs
  import lfc_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0000_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic              ien_q,
  output logic              locked_q,
  output logic              pre_wr,
  output logic              cnt_wr
);
  ctrl_t ctrl_d;
  logic  ien_d, locked_d, open_wr;

  assign open_wr = wr_en && !locked_q;
  assign pre_wr  = open_wr && (wr_addr == SEL_PRE);
  assign cnt_wr  = open_wr && (wr_addr == SEL_CNT);

  always_comb begin
    ctrl_d   = ctrl_q;
    ien_d    = ien_q;
    locked_d = locked_q;
    if (open_wr && wr_addr == SEL_CTRL) begin
      ctrl_d.run        = wr_data[0];
      ctrl_d.dbg_run    = wr_data[1];
      ctrl_d.pre_wrap   = wr_data[2];
      ctrl_d.cnt_wrap   = wr_data[3];
      ctrl_d.match_mode = wr_data[4];
      ctrl_d.code       = wr_data[8 +: CODE_W];
    end
    if (open_wr && wr_addr == SEL_IEN) ien_d = wr_data[0];
    if (wr_en && wr_addr == SEL_LOCK) locked_d = (wr_data != KEY[DATA_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ien_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      ien_q    <= ien_d;
      locked_q <= locked_d;
    end
  end

  // R9: a locked block keeps its control word through a write attempt
  a_r9_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && wr_addr == SEL_CTRL) |=> $stable(ctrl_q));
  // R9: a locked block keeps its interrupt enable
  a_r9_ien_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && wr_addr == SEL_IEN) |=> $stable(ien_q));
endmodule

// File: rtl/lfc_precnt.sv
module lfc_precnt #(
  parameter int PRE_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wrap_en,
  input  logic              match_mode,
  input  logic [CODE_W-1:0] code,
  input  logic [PRE_W-1:0]  cmp,
  input  logic              pre_wr,
  input  logic [PRE_W-1:0]  wr_val,
  output logic [PRE_W-1:0]  pre_q,
  output logic              main_tick
);
  localparam int NTAP = PRE_W + 1;

  logic [NTAP-1:0]  tap;
  logic [PRE_W-1:0] pre_d;
  logic             hit, presc_tick;

  genvar k;
  generate
    for (k = 0; k < NTAP; k++) begin : g_tap
      if (k == 0) begin : g_every
        assign tap[k] = 1'b1;
      end else begin : g_carry
        assign tap[k] = &pre_q[k-1:0];
      end
    end
  endgenerate

  assign presc_tick = (32'(code) < NTAP) ? tap[code] : 1'b0;
  assign hit        = (pre_q == cmp);
  assign main_tick  = cnt_en && (match_mode ? hit : presc_tick);

  always_comb begin
    pre_d = pre_q;
    if (pre_wr)              pre_d = wr_val;
    else if (cnt_en) begin
      if (wrap_en && hit)    pre_d = '0;
      else                   pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: wrap at the compare value returns the pre-counter to zero
  a_r4_pre_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wrap_en && pre_q == cmp && !pre_wr) |=> (pre_q == '0));
  // R7 / R8: with counting disabled and no write, the pre-counter holds
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !pre_wr) |=> $stable(pre_q));
  // R10: a software write lands on the next edge
  a_r10_pre_write: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> (pre_q == $past(wr_val)));
endmodule

// File: rtl/lfc_maincnt.sv
module lfc_maincnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d, at_end;

  assign at_end = (&cnt_q) || (wrap_en && cnt_q == cmp);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    if (cnt_wr) begin
      cnt_d = wr_val;
    end else if (tick) begin
      if (at_end) begin
        cnt_d = '0;
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R5: a tick at the channel-1 value with wrap enabled yields zero
  a_r5_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap_en && cnt_q == cmp && !cnt_wr) |=> (cnt_q == '0));
  // R11: the wrap pulse only accompanies a zero counter
  a_r11_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
  // R10: a software write wins over the increment
  a_r10_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_val) && !ovf_q));
endmodule

// File: rtl/lfc_tick_counter.sv
module lfc_tick_counter
  import lfc_pkg::*;
#(
  parameter int          PRE_W  = 15,
  parameter int          CNT_W  = 32,
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0000_C0DE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   dbg_halt,
  input  logic [PRE_W-1:0]       ch0_lo,
  input  logic [CNT_W-1:0]       ch1_val,
  output logic [CNT_W-1:0]       count,
  output logic [PRE_W-1:0]       precount,
  output logic [DATA_W-1:0]      combined,
  output logic                   ovf_pulse,
  output logic                   ovf_irq,
  output logic                   locked
);
  localparam int HI_W = DATA_W - PRE_W;

  logic  rst_meta, rst_s;
  ctrl_t ctrl;
  logic  ien, pre_wr, cnt_wr, cnt_en, main_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  lfc_regs #(.DATA_W(DATA_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl), .ien_q(ien), .locked_q(locked),
    .pre_wr(pre_wr), .cnt_wr(cnt_wr)
  );

  assign cnt_en = ctrl.run && (!dbg_halt || ctrl.dbg_run);

  lfc_precnt #(.PRE_W(PRE_W), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .cnt_en(cnt_en), .wrap_en(ctrl.pre_wrap),
    .match_mode(ctrl.match_mode), .code(ctrl.code), .cmp(ch0_lo),
    .pre_wr(pre_wr), .wr_val(wr_data[PRE_W-1:0]), .pre_q(precount),
    .main_tick(main_tick)
  );

  lfc_maincnt #(.CNT_W(CNT_W)) u_main (
    .clk(clk), .rst_n(rst_s), .tick(main_tick), .wrap_en(ctrl.cnt_wrap),
    .cmp(ch1_val), .cnt_wr(cnt_wr), .wr_val(wr_data[CNT_W-1:0]),
    .cnt_q(count), .ovf_q(ovf_pulse)
  );

  assign combined = {count[HI_W-1:0], precount};
  assign ovf_irq  = ovf_pulse && ien;

  // R8: a stopped block leaves the main counter alone unless written
  a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_s)
    (!ctrl.run && !cnt_wr) |=> $stable(count));
  // R7: halted without debug-run, the main counter holds
  a_r7_halt_main: assert property (@(posedge clk) disable iff (!rst_s)
    (dbg_halt && !ctrl.dbg_run && !cnt_wr) |=> $stable(count));
endmodule

// File: tb/tb_lfc_tick_counter.sv
module tb_lfc_tick_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dbg_halt = 1'b0;
  logic [14:0] ch0_lo = '0;
  logic [31:0] ch1_val = '0;
  logic [31:0] count, combined;
  logic [14:0] precount;
  logic        ovf_pulse, ovf_irq, locked;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lfc_tick_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dbg_halt(dbg_halt), .ch0_lo(ch0_lo),
    .ch1_val(ch1_val), .count(count), .precount(precount),
    .combined(combined), .ovf_pulse(ovf_pulse), .ovf_irq(ovf_irq),
    .locked(locked)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: act %0d exp below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act 0x%08h exp 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, load both counters, then write the control word
  task automatic config_run(logic [31:0] c, logic [31:0] cnt0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd2, cnt0);
    wr(3'd0, c);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 precount", 32'(precount), 0);
    check("R1 locked", 32'(locked), 0);
    check("R1 ovf", 32'(ovf_pulse), 0);
    edges(6);
    check("R8 stopped count", count, 0);
    check("R8 stopped precount", 32'(precount), 0);
  endtask

  task automatic t_prescale();
    config_run(32'h0000_0301, 0);
    edges(40);
    check("R2 div8 count", count, 5);
    check("R2 div8 precount", 32'(precount), 40);
    check("R6 combined", combined, (32'd5 << 15) | 32'd40);
    config_run(32'h0000_0001, 0);
    edges(7);
    check("R2 div1 count", count, 7);
    config_run(32'h0000_0F01, 0);
    edges(100);
    check("R2 div32768 count", count, 0);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0002_0003);
    check("R6 combined truncation", combined, (32'd3 << 15) | 32'(precount));
  endtask

  task automatic t_match();
    ch0_lo = 15'd5;
    config_run(32'h0000_0011, 0);
    edges(5);
    check("R3 before match", count, 0);
    edges(1);
    check("R3 at match", count, 1);
    check("R3 free-running pre", 32'(precount), 6);
  endtask

  task automatic t_prewrap();
    ch0_lo = 15'd4;
    config_run(32'h0000_0015, 0);
    edges(5);
    check("R4 pre wrapped", 32'(precount), 0);
    check("R4 count after wrap", count, 1);
    edges(7);
    check("R4 second period pre", 32'(precount), 2);
    check("R4 second period count", count, 2);
  endtask

  task automatic t_cntwrap();
    ch1_val = 32'd3;
    wr(3'd3, 32'h1);
    config_run(32'h0000_0009, 0);
    edges(3);
    check("R5 at compare", count, 3);
    check("R11 no pulse yet", 32'(ovf_pulse), 0);
    edges(1);
    check("R5 wrapped", count, 0);
    check("R11 pulse", 32'(ovf_pulse), 1);
    check("R11 irq", 32'(ovf_irq), 1);
    edges(1);
    check("R11 pulse one cycle", 32'(ovf_pulse), 0);
    check("R5 counts again", count, 1);
    wr(3'd3, 32'h0);
    config_run(32'h0000_0001, 32'hFFFF_FFFE);
    edges(1);
    check("R11 at all-ones", count, 32'hFFFF_FFFF);
    edges(1);
    check("R11 natural wrap count", count, 0);
    check("R11 natural wrap pulse", 32'(ovf_pulse), 1);
    check("R11 irq masked", 32'(ovf_irq), 0);
  endtask

  task automatic t_debug();
    config_run(32'h0000_0001, 0);
    dbg_halt = 1'b1;
    edges(5);
    check("R7 frozen pre", 32'(precount), 0);
    check("R7 frozen count", count, 0);
    dbg_halt = 1'b0;
    edges(3);
    check("R7 resumes", count, 3);
    config_run(32'h0000_0003, 0);
    dbg_halt = 1'b1;
    edges(4);
    check("R7 debug-run counts", 32'(precount), 4);
    dbg_halt = 1'b0;
  endtask

  task automatic t_lock();
    config_run(32'h0, 0);
    wr(3'd4, 32'h0000_1234);
    check("R9 locked", 32'(locked), 1);
    wr(3'd2, 32'd77);
    wr(3'd1, 32'd9);
    wr(3'd0, 32'h0000_0001);
    edges(5);
    check("R9 count write ignored", count, 0);
    check("R9 run write ignored", 32'(precount), 0);
    wr(3'd4, 32'h0000_C0DE);
    check("R9 unlocked", 32'(locked), 0);
    wr(3'd2, 32'd9);
    check("R9 write after unlock", count, 9);
  endtask

  task automatic t_override();
    config_run(32'h0000_0001, 0);
    edges(10);
    wr(3'd2, 32'd100);
    check("R10 count write wins", count, 100);
    check("R10 pre keeps counting", 32'(precount), 11);
    wr(3'd1, 32'd50);
    check("R10 pre write wins", 32'(precount), 50);
    check("R10 count ticks meanwhile", count, 101);
    edges(1);
    check("R10 after write", 32'(precount), 51);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(3);
    t_reset();
    t_prescale();
    t_match();
    t_prewrap();
    t_cntwrap();
    t_debug();
    t_lock();
    t_override();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule